// File: doc/BRIEF.md
# General-Purpose Timer with Cascaded Prescalers

This block is a free-running or restartable up-counter behind a flat 32-bit register bus. Software picks a count clock, sets division ratios, and enables the counter. The count clock is either every bus-clock cycle (peripheral source) or a single-cycle oscillator tick pulse, which is already synchronous to the bus clock. The oscillator path can pass through a 4-bit divider. That divider sits in front of the 12-bit main divider, so the two ratios multiply.

Three compare words raise sticky status flags when the counter meets them. Compare 1 can also restart the count. Two capture words are plain storage. A self-clearing soft reset returns the block to its defaults. The soft reset stays visible long enough for a polling loop to see it. The interrupt line combines the status flags with an enable mask.

Top module: `gp_timer`

## Requirements
- R1: After `rst`, these registers read 0: control, prescaler, status, interrupt enable, both capture words and the counter. All three compare words read 0xFFFFFFFF, and `irq` is 0.
- R2: Registers sit at word indices 0 to 9 on `bus_addr`: control, prescaler, status, interrupt enable, compare 1, compare 2, compare 3, capture 1, capture 2, counter. Compare and capture words read back what was written. The counter ignores writes. Any index above 9 reads 0.
- R3: Writing control with bit 15 set makes bit 15 read 1 for exactly `RST_CYC` cycles, after which it clears itself. At that point the registers return to their R1 values.
- R4: Control bit 0 enables counting. While it is 0, the counter holds its value.
- R5: The clock-source field is control bits 8:6. Value 1 counts on every cycle and value 5 counts on `osc_tick` pulses. Every other value stops counting.
- R6: Prescaler bits 11:0 hold N, and the counter advances once per N+1 source ticks.
- R7: Prescaler bits 15:12 hold M, and a divide-by-(M+1) stage is placed ahead of the main stage. This stage is used only when the source field is 5 and control bit 10 is set. In all other cases it is bypassed.
- R8: With control bit 9 set, the counter runs through compare 1 and wraps from its maximum value to 0.
- R9: With control bit 9 clear, a count tick that arrives while the counter equals compare 1 sends it to 0.
- R10: Status bit k (k = 0, 1, 2) is set by a count tick that arrives while the counter equals compare k+1. Writing 1 to that status bit clears it. A new match in the same cycle takes priority over the clear.
- R11: `irq` is high exactly when some status bit and the interrupt-enable bit in the same position (bits 2:0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| osc_tick | input | 1 | Oscillator tick pulse, synchronous to `clk` |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest state to reach from the ports is the counter's wrap, because a 32-bit counter needs billions of cycles to get there. The bench therefore builds the block with an 8-bit counter, so the wrap and the free-running pass over compare 1 appear after a few hundred cycles. Division-ratio checks depend on the phase of both dividers. For that reason, every stimulus vector first issues a soft reset, which clears both dividers and the counter. Only then does it program the ratios and enable counting, so that the expected count is floor(cycles/ratio).

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int REG_W      = 32;
    localparam int MAIN_PRE_W = 12;
    localparam int OSC_PRE_W  = 4;
    localparam int NUM_CMP    = 3;
    localparam int NUM_CAP    = 2;

    // Word indices on the register bus
    typedef enum logic [3:0] {
        RA_CTRL = 4'd0,
        RA_PRE  = 4'd1,
        RA_STAT = 4'd2,
        RA_IEN  = 4'd3,
        RA_CMP1 = 4'd4,
        RA_CMP2 = 4'd5,
        RA_CMP3 = 4'd6,
        RA_CAP1 = 4'd7,
        RA_CAP2 = 4'd8,
        RA_CNT  = 4'd9
    } reg_addr_e;

    localparam logic [2:0] SRC_PERIPH = 3'd1;
    localparam logic [2:0] SRC_OSC    = 3'd5;

    typedef struct packed {
        logic       swr;
        logic       osc_en;
        logic       frr;
        logic [2:0] src;
        logic       en;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [15:0] w);
        ctrl_t c;
        c.swr    = w[15];
        c.osc_en = w[10];
        c.frr    = w[9];
        c.src    = w[8:6];
        c.en     = w[0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] w;
        w       = '0;
        w[15]   = c.swr;
        w[10]   = c.osc_en;
        w[9]    = c.frr;
        w[8:6]  = c.src;
        w[0]    = c.en;
        return w;
    endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick_in,
    input  logic [W-1:0] div,
    output logic         tick_out
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    // >= keeps the divider sane if the ratio is lowered mid-run
    assign at_end   = (cnt_q >= div);
    assign tick_out = tick_in && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            tick,
    input  logic                            frr,
    input  logic [NUM_CMP-1:0][REG_W-1:0]   cmp,
    output logic [CNT_W-1:0]                cnt_q,
    output logic [NUM_CMP-1:0]              match
);
    logic [REG_W-1:0] cnt_wide;
    assign cnt_wide = REG_W'(cnt_q);

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        assign match[k] = tick && (cnt_wide == cmp[k]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (!frr && match[0]) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        osc_tick,
    output logic        irq
);
    localparam int RST_CW = $clog2(RST_CYC + 1);
    localparam int PRE_W  = MAIN_PRE_W + OSC_PRE_W;

    ctrl_t                          ctrl_q;
    logic [PRE_W-1:0]               pre_q;
    logic [NUM_CMP-1:0]             sr_q;
    logic [NUM_CMP-1:0]             ier_q;
    logic [NUM_CMP-1:0][REG_W-1:0]  cmp_q;
    logic [NUM_CAP-1:0][REG_W-1:0]  cap_q;
    logic [RST_CW-1:0]              swr_cnt_q;

    logic               busy, swr_done, wr_ok;
    logic               src_tick, osc_stage_on, presc_clr;
    logic               s1_tick, main_in, count_tick;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_CMP-1:0] match;

    assign busy     = ctrl_q.swr;
    assign swr_done = busy && (swr_cnt_q == RST_CW'(1));
    assign wr_ok    = bus_wr && !busy;

    // Tick source selection
    always_comb begin
        case (ctrl_q.src)
            SRC_PERIPH: src_tick = 1'b1;
            SRC_OSC:    src_tick = osc_tick;
            default:    src_tick = 1'b0;
        endcase
    end

    assign osc_stage_on = (ctrl_q.src == SRC_OSC) && ctrl_q.osc_en;
    assign presc_clr    = !ctrl_q.en || swr_done;

    gpt_prescaler #(.W(OSC_PRE_W)) i_osc_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (presc_clr),
        .tick_in  (src_tick && osc_stage_on),
        .div      (pre_q[PRE_W-1:MAIN_PRE_W]),
        .tick_out (s1_tick)
    );

    assign main_in = ctrl_q.en && (osc_stage_on ? s1_tick : src_tick);

    gpt_prescaler #(.W(MAIN_PRE_W)) i_main_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (presc_clr),
        .tick_in  (main_in),
        .div      (pre_q[MAIN_PRE_W-1:0]),
        .tick_out (count_tick)
    );

    gpt_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst   (rst),
        .clr   (swr_done),
        .tick  (count_tick),
        .frr   (ctrl_q.frr),
        .cmp   (cmp_q),
        .cnt_q (cnt_q),
        .match (match)
    );

    // Register file and soft-reset sequencing
    always_ff @(posedge clk) begin
        if (rst || swr_done) begin
            ctrl_q    <= '0;
            pre_q     <= '0;
            sr_q      <= '0;
            ier_q     <= '0;
            cmp_q     <= '1;
            cap_q     <= '0;
            swr_cnt_q <= '0;
        end else begin
            if (busy) swr_cnt_q <= swr_cnt_q - 1'b1;
            for (int k = 0; k < NUM_CMP; k++) begin
                if (match[k])
                    sr_q[k] <= 1'b1;
                else if (wr_ok && bus_addr == RA_STAT && bus_wdata[k])
                    sr_q[k] <= 1'b0;
            end
            if (wr_ok) begin
                case (bus_addr)
                    RA_CTRL: begin
                        if (bus_wdata[15]) begin
                            ctrl_q.swr <= 1'b1;
                            swr_cnt_q  <= RST_CW'(RST_CYC);
                        end else begin
                            ctrl_q <= ctrl_unpack(bus_wdata[15:0]);
                        end
                    end
                    RA_PRE:  pre_q    <= bus_wdata[PRE_W-1:0];
                    RA_IEN:  ier_q    <= bus_wdata[NUM_CMP-1:0];
                    RA_CMP1: cmp_q[0] <= bus_wdata;
                    RA_CMP2: cmp_q[1] <= bus_wdata;
                    RA_CMP3: cmp_q[2] <= bus_wdata;
                    RA_CAP1: cap_q[0] <= bus_wdata;
                    RA_CAP2: cap_q[1] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            RA_CTRL: bus_rdata = ctrl_pack(ctrl_q);
            RA_PRE:  bus_rdata = REG_W'(pre_q);
            RA_STAT: bus_rdata = REG_W'(sr_q);
            RA_IEN:  bus_rdata = REG_W'(ier_q);
            RA_CMP1: bus_rdata = cmp_q[0];
            RA_CMP2: bus_rdata = cmp_q[1];
            RA_CMP3: bus_rdata = cmp_q[2];
            RA_CAP1: bus_rdata = cap_q[0];
            RA_CAP2: bus_rdata = cap_q[1];
            RA_CNT:  bus_rdata = REG_W'(cnt_q);
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |(sr_q & ier_q);

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             en,
    input logic             frr,
    input logic             count_tick,
    input logic [CNT_W-1:0] cnt,
    input logic [31:0]      cmp1,
    input logic [31:0]      cmp2,
    input logic [2:0]       sr,
    input logic [15:0]      pre
);
    assert_swr_restores_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cnt == '0 && pre == '0 && sr == '0 && cmp1 == '1));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> (cnt == $past(cnt)));

    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (frr && count_tick && !busy && cnt == '1) |=> (cnt == '0));

    assert_restart_on_cmp1_R9: assert property (@(posedge clk) disable iff (rst)
        (!frr && count_tick && !busy && 32'(cnt) == cmp1) |=> (cnt == '0));

    assert_cmp2_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (count_tick && !busy && 32'(cnt) == cmp2) |=> sr[1]);
endmodule

bind gp_timer gpt_checker #(.CNT_W(CNT_W)) i_gpt_checker (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .en         (ctrl_q.en),
    .frr        (ctrl_q.frr),
    .count_tick (count_tick),
    .cnt        (cnt_q),
    .cmp1       (cmp_q[0]),
    .cmp2       (cmp_q[1]),
    .sr         (sr_q),
    .pre        (pre_q)
);

// File: tb/test_gp_timer.sv
module test_gp_timer;
    localparam int CNT_W   = 8;
    localparam int RST_CYC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        osc_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gp_timer #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) i_gp_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_tick(osc_tick), .irq(irq)
    );

    typedef struct packed {
        logic        tick;
        logic [2:0]  src;
        logic        osc_en;
        logic [3:0]  pro;
        logic [11:0] prm;
        logic [15:0] cyc;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 3'd1, 1'b0, 4'd0, 12'd0, 16'd10, 32'd10}, // R5 R6 divide by 1
        '{1'b0, 3'd1, 1'b0, 4'd0, 12'd3, 16'd20, 32'd5},  // R6 divide by 4
        '{1'b0, 3'd1, 1'b0, 4'd0, 12'd4, 16'd23, 32'd4},  // R6 partial period
        '{1'b1, 3'd5, 1'b1, 4'd1, 12'd1, 16'd20, 32'd5},  // R7 cascade 2x2
        '{1'b1, 3'd5, 1'b0, 4'd3, 12'd1, 16'd20, 32'd10}, // R7 osc stage bypassed
        '{1'b0, 3'd5, 1'b1, 4'd0, 12'd0, 16'd20, 32'd0},  // R5 no osc ticks
        '{1'b1, 3'd2, 1'b0, 4'd0, 12'd0, 16'd20, 32'd0},  // R5 unsupported source
        '{1'b1, 3'd1, 1'b1, 4'd7, 12'd0, 16'd9,  32'd9}   // R7 osc stage unused on peripheral
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic soft_reset();
        logic [31:0] d;
        int n;
        wr(4'd0, 32'h0000_8000);
        n = 0;
        rd(4'd0, d);
        while (d[15] && n < 50) begin
            @(posedge clk);
            #1;
            n++;
            rd(4'd0, d);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        rd(4'd0, d); check("R1 ctrl", d, 32'h0);
        rd(4'd1, d); check("R1 prescaler", d, 32'h0);
        rd(4'd2, d); check("R1 status", d, 32'h0);
        rd(4'd3, d); check("R1 int enable", d, 32'h0);
        rd(4'd4, d); check("R1 cmp1", d, 32'hFFFF_FFFF);
        rd(4'd6, d); check("R1 cmp3", d, 32'hFFFF_FFFF);
        rd(4'd9, d); check("R1 counter", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 register map
        wr(4'd5, 32'h1234_5678);
        rd(4'd5, d); check("R2 cmp2 readback", d, 32'h1234_5678);
        wr(4'd7, 32'hCAFE_0001);
        rd(4'd7, d); check("R2 cap1 readback", d, 32'hCAFE_0001);
        wr(4'd9, 32'h0000_0055);
        rd(4'd9, d); check("R2 counter ignores write", d, 32'h0);
        rd(4'd12, d); check("R2 unmapped index", d, 32'h0);

        // R3 soft reset timing and defaults
        wr(4'd3, 32'h7);
        wr(4'd1, 32'h0000_1123);
        wr(4'd0, 32'h0000_0241);
        repeat (3) @(posedge clk);
        wr(4'd0, 32'h0000_8000);
        n = 0;
        rd(4'd0, d);
        check("R3 swr reads 1 after write", {31'b0, d[15]}, 32'h1);
        while (d[15] && n < 50) begin
            @(posedge clk);
            #1;
            n++;
            rd(4'd0, d);
        end
        check("R3 swr busy cycles", n, RST_CYC);
        check("R3 ctrl cleared", d, 32'h0);
        rd(4'd1, d); check("R3 prescaler cleared", d, 32'h0);
        rd(4'd3, d); check("R3 int enable cleared", d, 32'h0);
        rd(4'd5, d); check("R3 cmp2 all ones", d, 32'hFFFF_FFFF);
        rd(4'd7, d); check("R3 cap1 cleared", d, 32'h0);
        rd(4'd9, d); check("R3 counter cleared", d, 32'h0);

        // R5 R6 R7 vector table
        for (int i = 0; i < 8; i++) begin
            soft_reset();
            osc_tick = VEC[i].tick;
            wr(4'd1, {16'b0, VEC[i].pro, VEC[i].prm});
            wr(4'd0, 32'h201 | (32'(VEC[i].src) << 6) | (32'(VEC[i].osc_en) << 10));
            repeat (int'(VEC[i].cyc)) @(posedge clk);
            #1;
            rd(4'd9, d);
            check($sformatf("R5/R6/R7 vector %0d", i), d, VEC[i].exp);
            osc_tick = 1'b0;
        end

        // R7 pulsed oscillator ticks, one every 3 cycles, cascade 2x1
        soft_reset();
        wr(4'd1, 32'h0000_1000);
        wr(4'd0, 32'h0000_0741);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            osc_tick = (i % 3 == 0);
            @(posedge clk);
        end
        #1;
        osc_tick = 1'b0;
        rd(4'd9, d); check("R7 pulsed osc ticks", d, 32'd5);

        // R4 enable off holds count
        soft_reset();
        wr(4'd0, 32'h0000_0241);
        repeat (5) @(posedge clk);
        wr(4'd0, 32'h0000_0240);
        repeat (10) @(posedge clk);
        #1;
        rd(4'd9, d); check("R4 hold when disabled", d, 32'd6);

        // R9 R10 R11 restart mode
        soft_reset();
        wr(4'd4, 32'd4);
        wr(4'd3, 32'd1);
        wr(4'd0, 32'h0000_0041);
        repeat (7) @(posedge clk);
        #1;
        rd(4'd9, d); check("R9 restart after cmp1", d, 32'd2);
        rd(4'd2, d); check("R10 cmp1 flag set", d, 32'd1);
        check("R11 irq asserted", {31'b0, irq}, 32'h1);
        wr(4'd2, 32'd1);
        rd(4'd2, d); check("R10 write-one clears", d, 32'd0);
        check("R11 irq drops", {31'b0, irq}, 32'h0);
        repeat (2) @(posedge clk);
        wr(4'd3, 32'd0);
        rd(4'd2, d); check("R10 flag set again", d, 32'd1);
        check("R11 irq masked", {31'b0, irq}, 32'h0);

        // R8 R10 free-running past cmp1 and wrap
        soft_reset();
        wr(4'd4, 32'd4);
        wr(4'd5, 32'd2);
        wr(4'd6, 32'd6);
        wr(4'd0, 32'h0000_0241);
        repeat (10) @(posedge clk);
        #1;
        rd(4'd9, d); check("R8 runs past cmp1", d, 32'd10);
        rd(4'd2, d); check("R10 all three flags", d, 32'd7);
        repeat (248) @(posedge clk);
        #1;
        rd(4'd9, d); check("R8 wrap to zero", d, 32'd2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule